// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block watches the input pins of one GPIO port and turns selected pin activity into a single interrupt line. Each pin has its own trigger type, mask bit and pending bit. The pin inputs are first brought into the clock domain. A per-pin detector then raises a one-cycle hit whenever the pin's trigger condition holds. Hits are latched into sticky pending bits. Software clears a pending bit by writing a one to it.

The port interrupt is raised when the port is enabled and at least one pending pin is also unmasked. The port owns a 5-bit slice of a control word that is shared among ports. The slice holds the port enable, a summary pending flag and a sample-clock select bit; the select bit is driven out to the clock logic.

The register bus is a simple strobe with no back-pressure. A write lands on the clock edge where `bus_valid_i` and `bus_write_i` are both high. Read data is combinational from `bus_addr_i` and carries no wait state. Register offsets are byte addresses:
- 0x00: trigger word for pins 16 and up
- 0x04: trigger word for pins 0 to 15
- 0x08: mask
- 0x0C: pending
- 0x10: control

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Each pin's 2-bit trigger field sits at bit (pin mod 16)*2. Pins 0 to 15 use the word at 0x04 and pins 16 to 31 use the word at 0x00. The field encodes 00 = rising edge, 01 = falling edge, 10 = level high and 11 = level low, and it reads back as written.
- R3: With a rising-edge type, a 0-to-1 pin change driven before clock edge k sets the pin's pending bit. The bit is readable just after edge k+2, and it is set once per transition only.
- R4: With a falling-edge type, a 1-to-0 pin change sets the pending bit with the same latency as R3. A 0-to-1 change does not set it.
- R5: With a level-high type, the pending bit is set on every cycle the synchronised pin is 1. A clear written while the level holds leaves it set.
- R6: With a level-low type, the pending bit is set on every cycle the synchronised pin is 0, and it stays clear after a clear while the pin is 1.
- R7: Pending bits are set whether or not the pin is masked. In the pending register (0x0C), writing 1 clears a bit and writing 0 has no effect.
- R8: `irq_o` is high exactly when the port enable is 1 and some pending bit has its mask bit set. It is low whenever the enable is 0.
- R9: The control slice starts at bit PORT_IDX*5 of the word at 0x10. Slice bit 0 is the enable, bit 1 is the summary pending flag and bit 2 is the sample-clock select, which drives `samp_sel_o`. All other control bits read 0 and ignore writes.
- R10: The summary pending flag is set on any cycle `irq_o` is high. Writing 1 to it clears it once `irq_o` is low.
- R11: Trigger, mask and pending bits for pins at or above NUM_PINS read as zero.
- R12: The mask register (0x08) reads back the value written to it. A mask bit of 1 enables that pin's interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | NUM_PINS | Raw pin levels, asynchronous |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| samp_sel_o | output | 1 | Sample-clock select from the control slice |
| irq_o | output | 1 | Port interrupt |

## Verification
The bench builds the block with NUM_PINS = 20 and PORT_IDX = 3. With 20 pins, the trigger word at 0x00 is only partly populated, so the bench can check that absent pins read zero. With PORT_IDX = 3, the control slice sits at bits 15 to 19 rather than at bit 0, so its placement is actually tested. A behavioural model holds a queue of past pin samples and tracks every register. On each clock it is compared against the interrupt line and against the read data of the addressed register, through directed edge and level scenarios and then a random mix of pin activity and bus writes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_TYPE_HI = 5'h00;
  localparam logic [REG_AW-1:0] OFS_TYPE_LO = 5'h04;
  localparam logic [REG_AW-1:0] OFS_MASK    = 5'h08;
  localparam logic [REG_AW-1:0] OFS_PEND    = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_CTRL    = 5'h10;

  localparam int CTL_SLICE_W = 5;
  localparam int CTL_EN      = 0;
  localparam int CTL_PEND    = 1;
  localparam int CTL_SEL     = 2;

  localparam int HALF_PINS   = 16;

  typedef enum logic [1:0] {
    TRIG_RISE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_HIGH = 2'b10,
    TRIG_LOW  = 2'b11
  } trig_e;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic [NUM_PINS-1:0] cur_o,
  output logic [NUM_PINS-1:0] prev_o
);

  logic [NUM_PINS-1:0] meta_q, cur_q, prev_q;

  // Two flops to resolve metastability, a third to hold the prior sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pins_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0][1:0] typ_i,
  input  logic [NUM_PINS-1:0]      cur_i,
  input  logic [NUM_PINS-1:0]      prev_i,
  output logic [NUM_PINS-1:0]      hit_o
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    always_comb begin
      case (trig_e'(typ_i[g]))
        TRIG_RISE: hit_o[g] =  cur_i[g] & ~prev_i[g];
        TRIG_FALL: hit_o[g] = ~cur_i[g] &  prev_i[g];
        TRIG_HIGH: hit_o[g] =  cur_i[g];
        default:   hit_o[g] = ~cur_i[g];
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int PORT_IDX = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_valid_i,
  input  logic                     bus_write_i,
  input  logic [REG_AW-1:0]        bus_addr_i,
  input  logic [31:0]              bus_wdata_i,
  input  logic [NUM_PINS-1:0]      hit_i,
  output logic [NUM_PINS-1:0][1:0] typ_o,
  output logic [31:0]              bus_rdata_o,
  output logic                     samp_sel_o,
  output logic                     irq_o
);

  localparam int SL = PORT_IDX * CTL_SLICE_W;

  logic wr, wr_tlo, wr_thi, wr_mask, wr_pend, wr_ctrl;
  logic [NUM_PINS-1:0][1:0] typ_q;
  logic [NUM_PINS-1:0]      mask_q, pend_q, clr_pend;
  logic                     en_q, sp_q, sel_q;

  assign wr      = bus_valid_i & bus_write_i;
  assign wr_tlo  = wr & (bus_addr_i == OFS_TYPE_LO);
  assign wr_thi  = wr & (bus_addr_i == OFS_TYPE_HI);
  assign wr_mask = wr & (bus_addr_i == OFS_MASK);
  assign wr_pend = wr & (bus_addr_i == OFS_PEND);
  assign wr_ctrl = wr & (bus_addr_i == OFS_CTRL);

  assign clr_pend = wr_pend ? bus_wdata_i[NUM_PINS-1:0] : '0;
  assign irq_o    = en_q & |(pend_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      typ_q  <= '0;
      mask_q <= '0;
      pend_q <= '0;
      en_q   <= 1'b0;
      sp_q   <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if ((i < HALF_PINS) ? wr_tlo : wr_thi)
          typ_q[i] <= bus_wdata_i[2*(i%HALF_PINS) +: 2];
      end
      if (wr_mask) mask_q <= bus_wdata_i[NUM_PINS-1:0];
      // a new hit wins over a clear in the same cycle
      pend_q <= (pend_q & ~clr_pend) | hit_i;
      if (wr_ctrl) begin
        en_q  <= bus_wdata_i[SL+CTL_EN];
        sel_q <= bus_wdata_i[SL+CTL_SEL];
      end
      sp_q <= (sp_q & ~(wr_ctrl & bus_wdata_i[SL+CTL_PEND])) | irq_o;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      OFS_TYPE_LO: for (int i = 0; i < NUM_PINS; i++)
                     if (i < HALF_PINS) bus_rdata_o[2*(i%HALF_PINS) +: 2] = typ_q[i];
      OFS_TYPE_HI: for (int i = 0; i < NUM_PINS; i++)
                     if (i >= HALF_PINS) bus_rdata_o[2*(i%HALF_PINS) +: 2] = typ_q[i];
      OFS_MASK:    bus_rdata_o[NUM_PINS-1:0] = mask_q;
      OFS_PEND:    bus_rdata_o[NUM_PINS-1:0] = pend_q;
      OFS_CTRL: begin
        bus_rdata_o[SL+CTL_EN]   = en_q;
        bus_rdata_o[SL+CTL_PEND] = sp_q;
        bus_rdata_o[SL+CTL_SEL]  = sel_q;
      end
      default: bus_rdata_o = '0;
    endcase
  end

  assign typ_o      = typ_q;
  assign samp_sel_o = sel_q;

  AST_HIT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_i) |=> ((pend_q & $past(hit_i)) == $past(hit_i))); // R3
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pend |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R7
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> ((pend_q & $past(bus_wdata_i[NUM_PINS-1:0] & ~hit_i)) == '0)); // R7
  AST_SUMMARY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> sp_q); // R10

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int PORT_IDX = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                bus_valid_i,
  input  logic                bus_write_i,
  input  logic [REG_AW-1:0]   bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  output logic                samp_sel_o,
  output logic                irq_o
);

  logic [NUM_PINS-1:0]      cur, prev, hit;
  logic [NUM_PINS-1:0][1:0] typ;

  gpio_irq_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .cur_o(cur), .prev_o(prev)
  );

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .typ_i(typ), .cur_i(cur), .prev_i(prev), .hit_o(hit)
  );

  gpio_irq_regs #(.NUM_PINS(NUM_PINS), .PORT_IDX(PORT_IDX)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .hit_i(hit), .typ_o(typ), .bus_rdata_o(bus_rdata_o),
    .samp_sel_o(samp_sel_o), .irq_o(irq_o)
  );

  // An edge trigger yields a single-cycle hit per pin transition.
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[g] && !typ[g][1]) |=> !(hit[g] && $stable(typ[g]))); // R4
  end

endmodule

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;

  localparam int NP = 20;
  localparam int PI = 3;
  localparam int SB = PI * 5;
  localparam logic [4:0] A_THI = 5'h00, A_TLO = 5'h04, A_MSK = 5'h08,
                         A_PND = 5'h0C, A_CTL = 5'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic bv = 1'b0, bw = 1'b0;
  logic [4:0] ba = A_PND;
  logic [31:0] bd = '0, rdata;
  logic samp_sel, irq;

  always #2 clk = ~clk;

  gpio_irq_port #(.NUM_PINS(NP), .PORT_IDX(PI)) i_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_valid_i(bv),
    .bus_write_i(bw), .bus_addr_i(ba), .bus_wdata_i(bd),
    .bus_rdata_o(rdata), .samp_sel_o(samp_sel), .irq_o(irq)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // behavioural model state
  int m_typ[NP];
  bit [NP-1:0] m_mask = '0, m_pend = '0;
  bit m_en = 0, m_sp = 0, m_sel = 0;
  bit [NP-1:0] hist[$] = '{'0, '0, '0};

  function automatic bit [31:0] exp_read(logic [4:0] a);
    bit [31:0] r = '0;
    if (a == A_TLO) begin
      for (int i = 0; i < NP && i < 16; i++) r[2*i +: 2] = m_typ[i][1:0];
    end else if (a == A_THI) begin
      for (int i = 16; i < NP; i++) r[2*(i-16) +: 2] = m_typ[i][1:0];
    end else if (a == A_MSK) r[NP-1:0] = m_mask;
    else if (a == A_PND) r[NP-1:0] = m_pend;
    else if (a == A_CTL) begin
      r[SB] = m_en; r[SB+1] = m_sp; r[SB+2] = m_sel;
    end
    return r;
  endfunction

  task automatic model_edge(bit v, bit w, logic [4:0] a, logic [31:0] d,
                            logic [NP-1:0] p);
    bit irq_old = m_en && ((m_pend & m_mask) != 0);
    bit [NP-1:0] hit = '0;
    bit wr = v && w;
    for (int i = 0; i < NP; i++) begin
      bit c = hist[1][i], q = hist[2][i];
      case (m_typ[i])
        0: hit[i] = c && !q;
        1: hit[i] = !c && q;
        2: hit[i] = c;
        default: hit[i] = !c;
      endcase
    end
    m_pend = (m_pend & ~((wr && a == A_PND) ? d[NP-1:0] : '0)) | hit;
    m_sp = (m_sp && !(wr && a == A_CTL && d[SB+1])) || irq_old;
    if (wr && a == A_CTL) begin m_en = d[SB]; m_sel = d[SB+2]; end
    if (wr && a == A_MSK) m_mask = d[NP-1:0];
    if (wr && a == A_TLO) for (int i = 0; i < NP && i < 16; i++) m_typ[i] = int'(d[2*i +: 2]);
    if (wr && a == A_THI) for (int i = 16; i < NP; i++) m_typ[i] = int'(d[2*(i-16) +: 2]);
    hist.push_front(p);
    void'(hist.pop_back());
  endtask

  task automatic step(string tag, bit v, bit w, logic [4:0] a, logic [31:0] d);
    bit ei;
    bit [31:0] er;
    @(negedge clk);
    bv = v; bw = w; ba = a; bd = d;
    @(posedge clk);
    model_edge(v, w, a, d, pins);
    #1;
    ei = m_en && ((m_pend & m_mask) != 0);
    er = exp_read(a);
    n_vec++;
    if (irq !== ei) begin
      n_bad++;
      $display("FAIL %s irq_o actual=%0b expected=%0b", tag, irq, ei);
    end
    n_vec++;
    if (rdata !== er) begin
      n_bad++;
      $display("FAIL %s rdata@%0h actual=%08h expected=%08h", tag, a, rdata, er);
    end
    n_vec++;
    if (samp_sel !== m_sel) begin
      n_bad++;
      $display("FAIL %s samp_sel_o actual=%0b expected=%0b", tag, samp_sel, m_sel);
    end
  endtask

  task automatic rd(string tag, logic [4:0] a);  step(tag, 1, 0, a, '0); endtask
  task automatic wrr(string tag, logic [4:0] a, logic [31:0] d); step(tag, 1, 1, a, d); endtask
  task automatic idle(string tag, int n);
    for (int k = 0; k < n; k++) step(tag, 0, 0, A_PND, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) m_typ[i] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset values
    rd("R1", A_THI); rd("R1", A_TLO); rd("R1", A_MSK); rd("R1", A_PND); rd("R1", A_CTL);
    // R2: field packing and split words
    wrr("R2", A_TLO, 32'h0000_00E4); rd("R2", A_TLO);
    wrr("R11", A_THI, 32'hFFFF_FFFF); rd("R11", A_THI);
    wrr("R2", A_THI, 32'h0000_0055); rd("R2", A_THI);
    // R12: mask
    wrr("R12", A_MSK, 32'hFFFF_FFFF); rd("R12", A_MSK);
    wrr("R7", A_PND, 32'hFFFF_FFFF); rd("R7", A_PND);
    // R9: control slice placement
    wrr("R9", A_CTL, 32'hFFFF_FFFF); rd("R9", A_CTL);
    wrr("R9", A_CTL, 32'h1 << SB); rd("R9", A_CTL);
    // R3: rising edge on pin 0
    pins[0] = 1'b1; idle("R3", 4); pins[0] = 1'b0; idle("R3", 4);
    wrr("R3", A_PND, 32'h1); idle("R3", 2);
    // R4: falling edge on pin 1
    pins[1] = 1'b1; idle("R4", 4); pins[1] = 1'b0; idle("R4", 4);
    wrr("R4", A_PND, 32'h2); idle("R4", 2);
    // R5: level high on pin 2
    pins[2] = 1'b1; idle("R5", 3); wrr("R5", A_PND, 32'h4); idle("R5", 2);
    pins[2] = 1'b0; idle("R5", 3); wrr("R5", A_PND, 32'h4); rd("R5", A_PND);
    // R6: level low on pin 3
    pins[3] = 1'b1; idle("R6", 3); wrr("R6", A_PND, 32'h8); idle("R6", 3); rd("R6", A_PND);
    pins[3] = 1'b0; idle("R6", 3);
    // R7: writing zeros leaves pending alone; masked pins still latch
    wrr("R7", A_PND, 32'h0); rd("R7", A_PND);
    wrr("R8", A_MSK, 32'h0); idle("R8", 2);
    pins[0] = 1'b1; idle("R7", 4); pins[0] = 1'b0; rd("R7", A_PND);
    wrr("R8", A_MSK, 32'hFFFF_FFFF); idle("R8", 2);
    wrr("R8", A_CTL, 32'h0); idle("R8", 2);
    // R10: summary flag clear once the line is low
    wrr("R10", A_CTL, 32'h1 << (SB+1)); rd("R10", A_CTL);
    wrr("R10", A_CTL, 32'h1 << SB); rd("R10", A_CTL);
    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [4:0] a;
      int sel = $urandom_range(0, 4);
      a = (sel == 0) ? A_THI : (sel == 1) ? A_TLO : (sel == 2) ? A_MSK :
          (sel == 3) ? A_PND : A_CTL;
      if ($urandom_range(0, 3) == 0) pins = NP'($urandom);
      if ($urandom_range(0, 4) == 0) wrr("R8", a, $urandom);
      else rd("R8", a);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule